// File: doc/BRIEF.md
# Level and Priority Interrupt Controller with Handler Chaining

This block sits next to a processor core and collects a parameterised set of interrupt sources (64 by default). Each source holds a pending bit, an enable bit, a trigger and vector attribute, and an 8-bit urgency byte. One global setting splits every urgency byte into an upper level part and a lower priority part. One threshold register masks every source whose level does not rise above it. Every cycle the block picks one winner among the sources that are pending and enabled and that clear the threshold. It compares level first, then priority, then the source number. It presents the winner to the core as a registered request with the winner's number, level and vectored flag.

Source numbers are labels only. By convention number 3 carries the core software interrupt, 7 the core timer, and 19 upward the external lines. Urgency comes from the urgency byte alone. The core acknowledges an edge-triggered interrupt through a claim port. From inside a handler, the core can ask for the next qualified interrupt through a chaining query. A hit returns the winner's number, clears its edge pending bit and tells the core to re-enable interrupts and jump. A miss returns no number and changes nothing, so the handler can simply return.

Configuration is written and read over a small valid/address/data bus. Address 0 holds the split width in bits [3:0], and address 1 holds the threshold. For a per-source register, the top address bit is 1, the source number sits in the bits between it and bit 2, and bits [1:0] choose the field: 0 pending, 1 enable, 2 attribute, 3 urgency.

Top module: `lpic_top`

## Requirements
- R1: While reset is high and right after it, irq_req, nxt_done and nxt_hit are 0. Every enable, attribute, split width and threshold reads 0. Every urgency byte reads only its unimplemented bits as 1 (0x0F with 4 implemented bits).
- R2: Only a source whose pending bit and enable bit (bit 0 of the enable field) are both 1 can raise irq_req.
- R3: A source can win only when its level is strictly greater than the threshold. A level equal to the threshold is masked.
- R4: With attribute bit 1 clear (level trigger), the pending bit follows the source input. A bus write to that pending bit has no effect.
- R5: With attribute bit 1 set (edge trigger), the pending bit is set on a rising input edge when attribute bit 2 is 0, and on a falling edge when it is 1. It then holds until a claim of that source, a chaining hit on it, or a bus write, which is allowed.
- R6: Among qualified sources the higher level wins. On equal level the higher priority wins. On equal level and priority the larger source number wins.
- R7: A split width L (0..8, values above 8 act as 8) makes the top L urgency bits the level. The level's lower 8-L bits read as 1, and the remaining urgency bits are the priority.
- R8: Only the upper CTL_BITS urgency bits are stored. The lower bits always read as 1.
- R9: irq_req, irq_id, irq_level and irq_vec (attribute bit 0) change together, one clock after the pending, enable or configuration state that decides them. A source input change therefore reaches irq_req two clocks later.
- R10: A chaining query gives nxt_done one clock later. It also gives nxt_hit and nxt_id for the winner at the query clock, and clears that winner's edge pending bit. With no winner, nxt_hit is 0, nxt_id is 0 and no pending bit changes.
- R11: A bus read returns the addressed register on bus_rdata one clock after the read is presented. Writes take effect at the clock that accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Interrupt source inputs, one per source number |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one clock after the read |
| claim_valid | input | 1 | Core acknowledges the source in claim_id |
| claim_id | input | IDW | Source being acknowledged |
| nxt_valid | input | 1 | Chaining query strobe |
| nxt_done | output | 1 | Query answer valid |
| nxt_hit | output | 1 | Query found a qualified interrupt; re-enable and jump |
| nxt_id | output | IDW | Source number returned by the query |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_id | output | IDW | Winning source number |
| irq_level | output | 8 | Winning level, lower bits filled with 1 |
| irq_vec | output | 1 | Winner uses vectored handling |

## Verification
Random rounds give every source a random trigger type, urgency byte, enable and input pattern, under a random threshold and split width. These rounds set the arbitration order and threshold masking against a bench model over many winners. Each round then chains queries until none qualifies and claims the last winner. This tells apart whether query and claim clear only edge pending bits and leave level sources untouched. Directed cases isolate the corners the random rounds rarely hit. They cover a threshold exactly equal to a level, exact ties broken by source number, priority losing to level, split widths above 8, bus writes to a level-triggered pending bit, a query that finds nothing, and the two-clock latency from input to request.

// File: rtl/lpic_pkg.sv
package lpic_pkg;

  localparam int URG_W = 8;

  // attribute field: bit0 vectored, bit1 edge trigger, bit2 falling edge
  typedef struct packed {
    logic is_fall;
    logic is_edge;
    logic is_vec;
  } attr_t;

  typedef enum logic [1:0] {
    F_IP   = 2'd0,
    F_IE   = 2'd1,
    F_ATTR = 2'd2,
    F_CTL  = 2'd3
  } field_e;

  // level = top nl bits of the urgency byte, lower bits forced to 1
  function automatic logic [URG_W-1:0] level_of(input logic [URG_W-1:0] urg,
                                                input logic [3:0] nl);
    logic [3:0] n;
    logic [URG_W-1:0] fill;
    n    = (nl > 4'd8) ? 4'd8 : nl;
    fill = (n == 4'd8) ? '0 : (8'hFF >> n);
    return urg | fill;
  endfunction

endpackage

// File: rtl/lpic_src.sv
module lpic_src
  import lpic_pkg::*;
#(
  parameter int CTL_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                src_in,
  input  logic                wr_ip,
  input  logic                ip_wval,
  input  logic                wr_ie,
  input  logic                ie_wval,
  input  logic                wr_attr,
  input  attr_t               attr_wval,
  input  logic                wr_ctl,
  input  logic [CTL_BITS-1:0] ctl_wval,
  input  logic                clr,
  output logic                ip,
  output logic                ie,
  output attr_t               attr,
  output logic [URG_W-1:0]    ctl
);

  localparam int PAD = URG_W - CTL_BITS;

  logic                src_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic                hit;

  always_comb begin
    hit = attr.is_edge & (attr.is_fall ? (src_q & ~src_in) : (~src_q & src_in));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      ip    <= 1'b0;
      ie    <= 1'b0;
      attr  <= '0;
      ctl_q <= '0;
    end else begin
      src_q <= src_in;
      if (wr_ie)   ie    <= ie_wval;
      if (wr_attr) attr  <= attr_wval;
      if (wr_ctl)  ctl_q <= ctl_wval;
      if (!attr.is_edge)  ip <= src_in;
      else if (hit)       ip <= 1'b1;
      else if (clr)       ip <= 1'b0;
      else if (wr_ip)     ip <= ip_wval;
    end
  end

  generate
    if (PAD == 0) begin : g_full
      assign ctl = ctl_q;
    end else begin : g_pad
      assign ctl = {ctl_q, {PAD{1'b1}}};
    end
  endgenerate

  // R4: level-triggered pending tracks the input of the previous clock
  p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(attr.is_edge)) |-> (ip == $past(src_in)));

  // R5: a detected edge leaves the pending bit set
  p_edge_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hit)) |-> ip);

  // R5: edge pending holds without edge, clear or write
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(attr.is_edge) && !$past(hit) && !$past(clr) && !$past(wr_ip))
      |-> $stable(ip));

endmodule

// File: rtl/lpic_arb.sv
module lpic_arb #(
  parameter int N   = 64,
  parameter int IDW = 6
) (
  input  logic [N-1:0]   qual,
  input  logic [7:0]     urg [N],
  output logic           hit,
  output logic [IDW-1:0] id,
  output logic [7:0]     win_urg
);

  // the urgency byte carries level above priority, so one compare
  // orders both; ">=" with ascending index favours the larger id
  always_comb begin
    hit     = 1'b0;
    id      = '0;
    win_urg = '0;
    for (int i = 0; i < N; i++) begin
      if (qual[i] && (!hit || urg[i] >= win_urg)) begin
        hit     = 1'b1;
        win_urg = urg[i];
        id      = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/lpic_top.sv
module lpic_top
  import lpic_pkg::*;
#(
  parameter  int N_SRC    = 64,
  parameter  int CTL_BITS = 4,
  parameter  int ADDR_W   = 12,
  localparam int IDW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              claim_valid,
  input  logic [IDW-1:0]    claim_id,
  input  logic              nxt_valid,
  output logic              nxt_done,
  output logic              nxt_hit,
  output logic [IDW-1:0]    nxt_id,
  output logic              irq_req,
  output logic [IDW-1:0]    irq_id,
  output logic [7:0]        irq_level,
  output logic              irq_vec
);

  localparam int IDX_W = ADDR_W - 3;

  logic              src_sel;
  logic [IDX_W-1:0]  idx;
  field_e            fld;
  logic              wr_src;
  logic              wr_cfg;
  logic              wr_thr;
  logic [3:0]        nlbits_q;
  logic [7:0]        thresh_q;

  logic [N_SRC-1:0]  ip_v;
  logic [N_SRC-1:0]  ie_v;
  logic [N_SRC-1:0]  qual;
  attr_t             attr_v [N_SRC];
  logic [7:0]        ctl_v  [N_SRC];

  logic              arb_hit;
  logic [IDW-1:0]    arb_id;
  logic [7:0]        arb_urg;
  logic [7:0]        rd_mux;

  assign src_sel = bus_addr[ADDR_W-1];
  assign idx     = bus_addr[ADDR_W-2:2];
  assign fld     = field_e'(bus_addr[1:0]);
  assign wr_src  = bus_valid && bus_we && src_sel;
  assign wr_cfg  = bus_valid && bus_we && !src_sel && (bus_addr[ADDR_W-2:0] == '0);
  assign wr_thr  = bus_valid && bus_we && !src_sel && (bus_addr[ADDR_W-2:0] == (ADDR_W-1)'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      nlbits_q <= '0;
      thresh_q <= '0;
    end else begin
      if (wr_cfg) nlbits_q <= bus_wdata[3:0];
      if (wr_thr) thresh_q <= bus_wdata;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic       sel;
    logic       clr;
    logic [7:0] lvl;

    assign sel = wr_src && (idx == IDX_W'(g));
    assign clr = (claim_valid && (claim_id == IDW'(g)))
              || (nxt_valid && arb_hit && (arb_id == IDW'(g)));

    lpic_src #(.CTL_BITS(CTL_BITS)) u_src (
      .clk       (clk),
      .rst       (rst),
      .src_in    (src_in[g]),
      .wr_ip     (sel && (fld == F_IP)),
      .ip_wval   (bus_wdata[0]),
      .wr_ie     (sel && (fld == F_IE)),
      .ie_wval   (bus_wdata[0]),
      .wr_attr   (sel && (fld == F_ATTR)),
      .attr_wval (attr_t'(bus_wdata[2:0])),
      .wr_ctl    (sel && (fld == F_CTL)),
      .ctl_wval  (bus_wdata[7 -: CTL_BITS]),
      .clr       (clr),
      .ip        (ip_v[g]),
      .ie        (ie_v[g]),
      .attr      (attr_v[g]),
      .ctl       (ctl_v[g])
    );

    assign lvl     = level_of(ctl_v[g], nlbits_q);
    assign qual[g] = ip_v[g] & ie_v[g] & (lvl > thresh_q);
  end

  lpic_arb #(.N(N_SRC), .IDW(IDW)) u_arb (
    .qual    (qual),
    .urg     (ctl_v),
    .hit     (arb_hit),
    .id      (arb_id),
    .win_urg (arb_urg)
  );

  always_comb begin
    rd_mux = '0;
    if (src_sel) begin
      for (int i = 0; i < N_SRC; i++) begin
        if (idx == IDX_W'(i)) begin
          case (fld)
            F_IP:    rd_mux = {7'b0, ip_v[i]};
            F_IE:    rd_mux = {7'b0, ie_v[i]};
            F_ATTR:  rd_mux = {5'b0, attr_v[i]};
            default: rd_mux = ctl_v[i];
          endcase
        end
      end
    end else if (bus_addr[ADDR_W-2:0] == '0) begin
      rd_mux = {4'b0, nlbits_q};
    end else if (bus_addr[ADDR_W-2:0] == (ADDR_W-1)'(1)) begin
      rd_mux = thresh_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_req   <= 1'b0;
      irq_id    <= '0;
      irq_level <= '0;
      irq_vec   <= 1'b0;
      nxt_done  <= 1'b0;
      nxt_hit   <= 1'b0;
      nxt_id    <= '0;
    end else begin
      if (bus_valid && !bus_we) bus_rdata <= rd_mux;
      irq_req   <= arb_hit;
      irq_id    <= arb_id;
      irq_level <= level_of(arb_urg, nlbits_q);
      irq_vec   <= attr_v[arb_id].is_vec;
      nxt_done  <= nxt_valid;
      nxt_hit   <= nxt_valid && arb_hit;
      nxt_id    <= (nxt_valid && arb_hit) ? arb_id : '0;
    end
  end

  logic [N_SRC-1:0] en_pend;
  assign en_pend = ip_v & ie_v;

  // R2: the request names a source that was pending and enabled
  p_req_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> |($past(en_pend) & (N_SRC'(1) << irq_id)));

  // R3: the presented level is strictly above the threshold in force
  p_req_thresh_r3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level > $past(thresh_q)));

  // R10: a query miss coincides with no request
  p_nxt_miss_r10: assert property (@(posedge clk) disable iff (rst)
    (nxt_done && !nxt_hit) |-> (!irq_req && (nxt_id == '0)));

endmodule

// File: tb/lpic_top_test.sv
module lpic_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 64;
  localparam int CTLB = 4;
  localparam int AW   = 12;
  localparam int IDW  = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   src = '0;
  logic           bus_valid = 1'b0;
  logic           bus_we = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic           claim_valid = 1'b0;
  logic [IDW-1:0] claim_id = '0;
  logic           nxt_valid = 1'b0;
  logic           nxt_done, nxt_hit;
  logic [IDW-1:0] nxt_id;
  logic           irq_req;
  logic [IDW-1:0] irq_id;
  logic [7:0]     irq_level;
  logic           irq_vec;

  lpic_top #(.N_SRC(N), .CTL_BITS(CTLB), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .src_in(src),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .claim_valid(claim_valid), .claim_id(claim_id),
    .nxt_valid(nxt_valid), .nxt_done(nxt_done), .nxt_hit(nxt_hit), .nxt_id(nxt_id),
    .irq_req(irq_req), .irq_id(irq_id), .irq_level(irq_level), .irq_vec(irq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit       m_ie   [N];
  bit [2:0] m_attr [N];
  bit [7:0] m_ctl  [N];
  bit       m_ip   [N];
  int       m_thr;
  int       m_nl;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int i);
    return int'(m_ctl[i]) | (255 >> CTLB);
  endfunction

  function automatic int lvl_of(input int c);
    int n;
    int mask;
    n    = (m_nl > 8) ? 8 : m_nl;
    mask = (n >= 8) ? 0 : (255 >> n);
    return (c | mask) & 255;
  endfunction

  function automatic void model_win(output bit h, output int id);
    int best;
    bit p;
    best = 0; h = 1'b0; id = 0;
    for (int i = 0; i < N; i++) begin
      p = m_attr[i][1] ? m_ip[i] : src[i];
      if (p && m_ie[i] && lvl_of(eff(i)) > m_thr && (!h || eff(i) >= best)) begin
        h = 1'b1; best = eff(i); id = i;
      end
    end
  endfunction

  function automatic logic [AW-1:0] sa(input int i, input int f);
    return AW'(12'h800 | (i << 2) | f);
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input int d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = 8'(d);
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output int d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [AW-1:0] a, input int exp);
    int d;
    bus_rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic w_attr(input int i, input int v);
    if (!m_attr[i][1] && v[1]) m_ip[i] = src[i];
    m_attr[i] = 3'(v);
    bus_wr(sa(i, 2), v);
  endtask
  task automatic w_ie(input int i, input int v);  m_ie[i] = v[0];  bus_wr(sa(i, 1), v); endtask
  task automatic w_ctl(input int i, input int v); m_ctl[i] = 8'(v); bus_wr(sa(i, 3), v); endtask
  task automatic w_ip(input int i, input int v);
    if (m_attr[i][1]) m_ip[i] = v[0];
    bus_wr(sa(i, 0), v);
  endtask
  task automatic w_cfg(input int v); m_nl = v & 15; bus_wr(AW'(0), v); endtask
  task automatic w_thr(input int v); m_thr = v & 255; bus_wr(AW'(1), v); endtask

  // caller stands at a negedge; pending changes at the next posedge
  task automatic drive_src(input int i, input bit v);
    if (m_attr[i][1]) begin
      if (!m_attr[i][2] && !src[i] && v) m_ip[i] = 1'b1;
      if (m_attr[i][2] && src[i] && !v)  m_ip[i] = 1'b1;
    end
    src[i] = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      m_ie[i] = 1'b0; m_attr[i] = '0; m_ctl[i] = '0; m_ip[i] = 1'b0;
    end
    m_thr = 0; m_nl = 0;
    rst = 1'b0;
  endtask

  task automatic check_irq(input string req);
    bit h;
    int id;
    repeat (3) @(negedge clk);
    model_win(h, id);
    chk(req, "irq_req", int'(irq_req), int'(h));
    if (h) begin
      chk(req, "irq_id", int'(irq_id), id);
      chk(req, "irq_level", int'(irq_level), lvl_of(eff(id)));
      chk(req, "irq_vec", int'(irq_vec), int'(m_attr[id][0]));
    end
  endtask

  task automatic query(input string req, output bit h);
    int id;
    repeat (2) @(negedge clk);
    model_win(h, id);
    nxt_valid = 1'b1;
    @(negedge clk);
    nxt_valid = 1'b0;
    chk(req, "nxt_done", int'(nxt_done), 1);
    chk(req, "nxt_hit", int'(nxt_hit), int'(h));
    chk(req, "nxt_id", int'(nxt_id), h ? id : 0);
    if (h && m_attr[id][1]) m_ip[id] = 1'b0;
  endtask

  task automatic claim(input int id);
    @(negedge clk);
    claim_valid = 1'b1; claim_id = IDW'(id);
    @(negedge clk);
    claim_valid = 1'b0;
    if (m_attr[id][1]) m_ip[id] = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    bit h;
    int d;
    void'($urandom(32'h1C0FFEE));

    // ---------- R1 / R8 / R11: reset state and readback ----------
    do_reset();
    @(negedge clk);
    chk("R1", "irq_req after reset", int'(irq_req), 0);
    chk("R1", "nxt_done after reset", int'(nxt_done), 0);
    rd_chk("R1", "urgency reset (R8 low bits 1)", sa(5, 3), 8'h0F);
    rd_chk("R1", "attr reset", sa(5, 2), 0);
    rd_chk("R1", "enable reset", sa(5, 1), 0);
    rd_chk("R1", "split reset", AW'(0), 0);
    rd_chk("R1", "threshold reset", AW'(1), 0);
    w_ctl(5, 8'hA5);
    rd_chk("R8", "urgency 0xA5 readback", sa(5, 3), 8'hAF);
    w_thr(8'h33);
    rd_chk("R11", "threshold readback", AW'(1), 8'h33);

    // ---------- R4: level pending ignores bus writes ----------
    do_reset();
    @(negedge clk); drive_src(10, 1'b1);
    repeat (2) @(negedge clk);
    rd_chk("R4", "level pending high", sa(10, 0), 1);
    w_ip(10, 0);
    rd_chk("R4", "level pending after write 0", sa(10, 0), 1);
    @(negedge clk); drive_src(10, 1'b0);
    w_ip(10, 1);
    rd_chk("R4", "level pending after write 1", sa(10, 0), 0);

    // ---------- R5: edge capture, hold, claim, software write ----------
    do_reset();
    w_attr(20, 3'b010);
    @(negedge clk); drive_src(20, 1'b1);
    rd_chk("R5", "rising edge sets pending", sa(20, 0), 1);
    @(negedge clk); drive_src(20, 1'b0);
    rd_chk("R5", "pending holds after input falls", sa(20, 0), 1);
    claim(20);
    rd_chk("R5", "claim clears pending", sa(20, 0), 0);
    @(negedge clk); drive_src(21, 1'b1);
    w_attr(21, 3'b110);
    w_ip(21, 0);
    rd_chk("R5", "falling source cleared", sa(21, 0), 0);
    @(negedge clk); drive_src(21, 1'b0);
    rd_chk("R5", "falling edge sets pending", sa(21, 0), 1);
    w_attr(22, 3'b010);
    w_ip(22, 1);
    rd_chk("R5", "software sets edge pending", sa(22, 0), 1);

    // ---------- R9: latency and vectored flag ----------
    do_reset();
    w_ie(33, 1); w_ctl(33, 8'h90); w_attr(33, 3'b001);
    @(negedge clk); drive_src(33, 1'b1);
    @(negedge clk);
    chk("R9", "irq_req one clock after input", int'(irq_req), 0);
    @(negedge clk);
    chk("R9", "irq_req two clocks after input", int'(irq_req), 1);
    chk("R9", "irq_vec vectored", int'(irq_vec), 1);
    chk("R9", "irq_id", int'(irq_id), 33);
    w_ie(33, 0);
    check_irq("R2");

    // ---------- R3: threshold equal masks ----------
    do_reset();
    w_cfg(8);
    w_ie(30, 1); w_ctl(30, 8'h80);
    @(negedge clk); drive_src(30, 1'b1);
    w_thr(8'h8F);
    repeat (3) @(negedge clk);
    chk("R3", "level equal to threshold masked", int'(irq_req), 0);
    w_thr(8'h8E);
    repeat (3) @(negedge clk);
    chk("R3", "level above threshold requests", int'(irq_req), 1);
    chk("R3", "level value", int'(irq_level), 8'h8F);

    // ---------- R6: tie, priority, level ----------
    do_reset();
    w_cfg(2);
    w_ie(40, 1); w_ie(41, 1); w_ctl(40, 8'h60); w_ctl(41, 8'h60);
    @(negedge clk); drive_src(40, 1'b1); drive_src(41, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6", "tie goes to larger id", int'(irq_id), 41);
    w_ctl(40, 8'h70);
    repeat (3) @(negedge clk);
    chk("R6", "priority breaks equal level", int'(irq_id), 40);
    w_ctl(41, 8'h80);
    repeat (3) @(negedge clk);
    chk("R6", "level beats priority", int'(irq_id), 41);
    chk("R7", "two level bits fill", int'(irq_level), 8'hBF);

    // ---------- R7: split width clamp ----------
    do_reset();
    w_cfg(12);
    rd_chk("R7", "split readback", AW'(0), 12);
    w_ie(50, 1); w_ctl(50, 8'h50);
    @(negedge clk); drive_src(50, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7", "width above 8 acts as 8", int'(irq_level), 8'h5F);
    w_cfg(0);
    repeat (3) @(negedge clk);
    chk("R7", "width 0 gives full level", int'(irq_level), 8'hFF);

    // ---------- R10: query miss and hit ----------
    do_reset();
    w_attr(22, 3'b011);
    @(negedge clk); drive_src(22, 1'b1);
    query("R10", h);
    chk("R10", "miss reports none", int'(h), 0);
    rd_chk("R10", "miss leaves pending", sa(22, 0), 1);
    w_ie(22, 1); w_ctl(22, 8'hC0);
    check_irq("R9");
    query("R10", h);
    chk("R10", "hit found", int'(h), 1);
    rd_chk("R10", "hit clears edge pending", sa(22, 0), 0);
    check_irq("R10");

    // ---------- random rounds ----------
    do_reset();
    for (int it = 0; it < 30; it++) begin
      int na [N];
      bit hh;
      int wid;
      for (int i = 0; i < N; i++) begin
        int t;
        t = int'($urandom % 3);
        na[i] = (t == 0 ? 0 : (t == 1 ? 3'b010 : 3'b110)) | int'($urandom % 2);
        w_attr(i, 0);
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (na[i][1]) drive_src(i, na[i][2]);
        else          drive_src(i, 1'($urandom % 2));
      end
      for (int i = 0; i < N; i++) begin
        w_attr(i, na[i]);
        if (na[i][1]) w_ip(i, 0);
        w_ctl(i, int'($urandom % 256));
        w_ie(i, int'($urandom % 2));
      end
      w_thr(int'($urandom % 200));
      w_cfg(int'($urandom % 10));
      @(negedge clk);
      for (int i = 0; i < N; i++)
        if (na[i][1] && ($urandom % 2) == 1) drive_src(i, !na[i][2]);
      check_irq("R6");
      for (int k = 0; k < 4; k++) begin
        query("R10", hh);
        check_irq("R3");
        if (!hh) break;
      end
      model_win(hh, wid);
      if (hh) begin
        claim(wid);
        check_irq("R5");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule